// File: doc/BRIEF.md
# Fault-Aware ALU Issue Selector

This block picks, once per cycle, which integer ALU of a four-unit in-order execution cluster receives the next ready instruction. Each ALU reports whether it can take an operation this cycle and carries a status bit, fixed at test time, that marks it as defective but repairable. A defective unit still computes correct results, but it needs several cycles to do so. The selector therefore treats it as a last resort. It is used only when every sound unit is busy.

Along with the chosen unit, the selector returns the number of cycles to wait before instructions that depend on the result may wake. For a sound unit this is the normal single-cycle latency. For a defective unit it is that unit's configured repair latency. After a defective unit is chosen, the selector keeps it out of selection until its multi-cycle operation has finished. If an instruction is ready and no unit qualifies, the selector raises a stall instead of issuing.

Top module: `alu_issue_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `issue_grant`, `issue_stall`, `issue_unit` and `wake_lat` are all 0.
- R2: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and a grant only ever names a unit whose `unit_avail` bit was 1 at that edge.
- R3: When at least one available unit has its `unit_fault` bit at 0, the unit granted is the lowest-indexed such unit.
- R4: A unit with `unit_fault` = 1 is granted only when no fault-free unit is available. Among the eligible faulty units, the lowest index wins.
- R5: When a fault-free unit is granted, `wake_lat` is 1.
- R6: When a faulty unit u is granted, `wake_lat` equals the 2-bit field `repair_lat[2u+1:2u]`. A field value of 0 or 1 is read as 2.
- R7: After faulty unit u is granted with latency L, it is not granted again on the next L-1 edges, even if its `unit_avail` bit stays 1.
- R8: When `issue_req` is 1 and no unit is eligible, `issue_stall` is 1 and `issue_grant` is 0 on the following cycle.
- R9: When `issue_req` is 0, neither `issue_grant` nor `issue_stall` is raised on the following cycle, whatever the availability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_req | input | 1 | A ready instruction wants a unit this cycle |
| unit_avail | input | 4 | Per-unit "can accept an operation" flags |
| unit_fault | input | 4 | Per-unit static defect flags, set at test time |
| repair_lat | input | 8 | Per-unit repair latency, 2 bits per unit, unit 0 in the low bits |
| issue_grant | output | 1 | An instruction was issued |
| issue_unit | output | 2 | Index of the unit chosen |
| wake_lat | output | 2 | Cycles until dependents may wake |
| issue_stall | output | 1 | Instruction ready but no unit eligible |

## Verification
Every result appears exactly one clock edge after the request that caused it. The bench therefore drives inputs on the falling edge and reads the outputs shortly after the next rising edge. The exclusion of a faulty unit (R7) is measured in edges counted from its grant. The bench walks a held request across consecutive edges and expects a grant, then a substitute or a stall, then the original unit again at the predicted edge. Reset values are read one edge after reset asserts, before any request is applied.

// File: rtl/alu_issue_pkg.sv
// Package: shared constants for the fault-aware ALU issue selector.
// Assumes latency fields are wide enough to hold MIN_REPAIR_LAT.
package alu_issue_pkg;
    // Dependent wakeup delay for a sound unit.
    localparam int NORM_LAT_CYC   = 1;
    // Smallest repair latency a faulty unit may be given.
    localparam int MIN_REPAIR_LAT = 2;
endpackage

// File: rtl/alu_issue_hold.sv
// Module: alu_issue_hold
// Per-unit busy counter. A load starts a window of load_val cycles during
// which 'held' is high; the counter then counts down to zero.
// Assumes load_val is the repair latency minus one (1..max).
module alu_issue_hold #(
    parameter int LAT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             held
);
    logic [LAT_W-1:0] cnt_q;

    // Load the busy window on a grant, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign held = (cnt_q != '0);

    // R7: an unreloaded busy window shrinks by exactly one per cycle.
    a_r7_window_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/alu_issue_pick.sv
// Module: alu_issue_pick
// Two-tier lowest-index picker: any set bit of good_mask beats every bit of
// bad_mask. Purely combinational.
// Assumes both masks already contain only units able to take work.
module alu_issue_pick #(
    parameter int N_UNITS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_UNITS-1:0] good_mask,
    input  logic [N_UNITS-1:0] bad_mask,
    output logic               found,
    output logic               pick_bad,
    output logic [IDX_W-1:0]   pick_idx
);
    // Scan from the top so that the lowest set index is kept last.
    always_comb begin
        found    = 1'b0;
        pick_bad = 1'b0;
        pick_idx = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (good_mask[i]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
        if (!found) begin
            for (int i = N_UNITS - 1; i >= 0; i--) begin
                if (bad_mask[i]) begin
                    found    = 1'b1;
                    pick_bad = 1'b1;
                    pick_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/alu_issue_sched.sv
// Module: alu_issue_sched
// Chooses an ALU for the ready instruction each cycle. Sound units come first,
// lowest index first. A faulty unit is chosen only as a fallback and is then
// kept out of selection for its repair window. Returns the chosen unit and the
// dependent-wakeup latency, all registered.
// Assumes unit_fault and repair_lat are static while out of reset.
module alu_issue_sched #(
    parameter int N_UNITS = 4,
    parameter int LAT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_req,
    input  logic [N_UNITS-1:0]       unit_avail,
    input  logic [N_UNITS-1:0]       unit_fault,
    input  logic [N_UNITS*LAT_W-1:0] repair_lat,
    output logic                     issue_grant,
    output logic [$clog2(N_UNITS)-1:0] issue_unit,
    output logic [LAT_W-1:0]         wake_lat,
    output logic                     issue_stall
);
    import alu_issue_pkg::*;

    localparam int IDX_W = $clog2(N_UNITS);
    localparam logic [LAT_W-1:0] NORM_LAT = LAT_W'(NORM_LAT_CYC);
    localparam logic [LAT_W-1:0] MIN_LAT  = LAT_W'(MIN_REPAIR_LAT);

    logic [N_UNITS-1:0] held;
    logic [N_UNITS-1:0] good_mask;
    logic [N_UNITS-1:0] bad_mask;
    logic [LAT_W-1:0]   eff_lat [N_UNITS];
    logic               found;
    logic               pick_bad;
    logic [IDX_W-1:0]   pick_idx;
    logic               do_issue;

    assign do_issue = issue_req && found;

    // Per-unit latency clamp, eligibility masks and busy counters.
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic [LAT_W-1:0] raw_lat;
        assign raw_lat    = repair_lat[u*LAT_W +: LAT_W];
        assign eff_lat[u] = (raw_lat < MIN_LAT) ? MIN_LAT : raw_lat;
        assign good_mask[u] = unit_avail[u] && !unit_fault[u];
        assign bad_mask[u]  = unit_avail[u] && unit_fault[u] && !held[u];

        alu_issue_hold #(.LAT_W(LAT_W)) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (do_issue && pick_bad && (pick_idx == IDX_W'(u))),
            .load_val (eff_lat[u] - 1'b1),
            .held     (held[u])
        );
    end

    alu_issue_pick #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_pick (
        .good_mask (good_mask),
        .bad_mask  (bad_mask),
        .found     (found),
        .pick_bad  (pick_bad),
        .pick_idx  (pick_idx)
    );

    // Register the issue decision and its wakeup latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_grant <= 1'b0;
            issue_unit  <= '0;
            wake_lat    <= '0;
            issue_stall <= 1'b0;
        end else begin
            issue_grant <= do_issue;
            issue_stall <= issue_req && !found;
            issue_unit  <= do_issue ? pick_idx : '0;
            if (!do_issue)
                wake_lat <= '0;
            else if (pick_bad)
                wake_lat <= eff_lat[pick_idx];
            else
                wake_lat <= NORM_LAT;
        end
    end

    // R2: a grant names a unit that was available at the sampling edge.
    a_r2_grant_was_avail: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> ((($past(unit_avail)) >> issue_unit) & N_UNITS'(1)) != '0);

    // R4: a stretched latency means no sound unit was free.
    a_r4_fault_is_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && wake_lat != NORM_LAT) |-> ($past(unit_avail & ~unit_fault) == '0));

    // R5: a sound unit always yields the normal latency.
    a_r5_sound_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && ((($past(unit_fault)) >> issue_unit) & N_UNITS'(1)) == '0)
            |-> (wake_lat == NORM_LAT));

    // R7: a faulty unit is not granted on the edge straight after its grant.
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && wake_lat >= MIN_LAT)
            |=> !(issue_grant && issue_unit == $past(issue_unit)));

    // R8: stall and grant never coincide.
    a_r8_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_grant && issue_stall));

    // R9: no request, no outcome.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(issue_req) |-> !(issue_grant || issue_stall));
endmodule

// File: tb/alu_issue_sched_test.sv
// Directed bench for alu_issue_sched: inputs change on the falling edge,
// outputs are read 1 ns after the rising edge.
module alu_issue_sched_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       issue_req;
    logic [3:0] unit_avail;
    logic [3:0] unit_fault;
    logic [7:0] repair_lat;
    logic       issue_grant;
    logic [1:0] issue_unit;
    logic [1:0] wake_lat;
    logic       issue_stall;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk; // 250 MHz

    alu_issue_sched uut (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req),
        .unit_avail(unit_avail), .unit_fault(unit_fault),
        .repair_lat(repair_lat), .issue_grant(issue_grant),
        .issue_unit(issue_unit), .wake_lat(wake_lat),
        .issue_stall(issue_stall)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One request edge, then compare all four outputs.
    task automatic step(input string req, input logic r, input logic [3:0] av,
                        input int g, input int u, input int l, input int s);
        @(negedge clk);
        issue_req  = r;
        unit_avail = av;
        @(posedge clk);
        #1;
        chk(req, "grant", int'(issue_grant), g);
        chk(req, "unit",  int'(issue_unit),  u);
        chk(req, "lat",   int'(wake_lat),    l);
        chk(req, "stall", int'(issue_stall), s);
    endtask

    task automatic do_reset(input logic [3:0] flt, input logic [7:0] lat);
        @(negedge clk);
        rst_n = 1'b0; issue_req = 1'b1; unit_avail = 4'hF;
        unit_fault = flt; repair_lat = lat;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "grant in reset", int'(issue_grant), 0);
        chk("R1", "stall in reset", int'(issue_stall), 0);
        @(negedge clk);
        rst_n = 1'b1; issue_req = 1'b0;
    endtask

    // R1: outputs are zero out of reset with no request applied.
    task automatic t_reset();
        do_reset(4'h0, 8'hFF);
        step("R1", 1'b0, 4'h0, 0, 0, 0, 0);
    endtask

    // R2, R3, R5: sound units, lowest index, latency 1.
    task automatic t_sound();
        do_reset(4'h0, 8'hFF);
        step("R3", 1'b1, 4'hF, 1, 0, 1, 0);
        step("R3", 1'b1, 4'hC, 1, 2, 1, 0);
        step("R2", 1'b1, 4'h8, 1, 3, 1, 0);
        step("R5", 1'b1, 4'h4, 1, 2, 1, 0);
        do_reset(4'h5, 8'hFF);
        step("R3", 1'b1, 4'hF, 1, 1, 1, 0);
    endtask

    // R4, R6, R7, R8: fallback to faulty units and their busy windows.
    // Latencies: u0=3, u1=0 (read as 2), u2=2, u3=3.
    task automatic t_fault();
        do_reset(4'h3, 8'b11_10_00_11);
        step("R4", 1'b1, 4'h7, 1, 2, 1, 0);
        step("R6", 1'b1, 4'h3, 1, 0, 3, 0);
        step("R7", 1'b1, 4'h3, 1, 1, 2, 0);
        step("R7", 1'b1, 4'h3, 0, 0, 0, 1);
        step("R7", 1'b1, 4'h3, 1, 0, 3, 0);
        do_reset(4'hF, 8'b11_10_00_11);
        step("R6", 1'b1, 4'h4, 1, 2, 2, 0);
        step("R7", 1'b1, 4'h4, 0, 0, 0, 1);
        step("R7", 1'b1, 4'h4, 1, 2, 2, 0);
    endtask

    // R8, R9: stall when nothing is free; quiet without a request.
    task automatic t_idle();
        do_reset(4'h0, 8'hFF);
        step("R8", 1'b1, 4'h0, 0, 0, 0, 1);
        step("R9", 1'b0, 4'hF, 0, 0, 0, 0);
        step("R2", 1'b1, 4'h2, 1, 1, 1, 0);
    endtask

    initial begin
        rst_n = 1'b0; issue_req = 1'b0; unit_avail = '0;
        unit_fault = '0; repair_lat = '0;
        t_reset();
        t_sound();
        t_fault();
        t_idle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule